// File: doc/BRIEF.md
# Hypervisor Interrupt Target Resolver

This block sits beside the trap logic of a hart that implements the hypervisor extension. On every clock it looks at the pending and enable vectors, the machine delegation mask, the guest delegation register it holds, the current privilege level, the virtualization flag and the three global enable bits. From these it decides whether an interrupt must be taken and which mode takes it: machine (M), hypervisor-supervisor (HS) or virtual supervisor (VS). It also reports the cause number. The decision is registered and appears one clock after the inputs that produce it.

Two rules set it apart. First, a guest-level interrupt whose guest delegation bit is clear still counts as an HS candidate. Second, while the hart runs virtualized, HS treats every interrupt as globally enabled, whatever its own SIE bit holds. The guest delegation register keeps only the three guest interrupt bits. Software writes it through a simple write strobe and data port and reads it back on a dedicated output.

Top module: `hyp_irq_router`

## Requirements
- R1: A synchronous active-high reset clears the take strobe, the target and the cause to zero, and it clears the guest delegation register to zero.
- R2: A write to the guest delegation register stores only bits 2, 6 and 10 of the written data. Every other bit reads back as zero.
- R3: The guest interrupts (bit 2 software, bit 6 timer, bit 10 external) are never taken in M mode, whatever the machine delegation mask holds at those bits.
- R4: A pending and enabled interrupt whose machine delegation bit is clear is taken in M (target code 0) when the privilege is below M (privilege codes 0 = U, 1 = S, 3 = M), or when it is M with the M-level enable set.
- R5: While virtualized, a pending and enabled interrupt that is delegated by the machine mask and not by the guest delegation register is taken in HS (target code 1). This includes the guest bits 2, 6 and 10, and it holds even when the HS-level enable is clear.
- R6: When not virtualized, an HS-bound interrupt is taken only in U mode, or in S mode with the HS-level enable set. It is never taken in M mode.
- R7: A guest interrupt whose guest delegation bit is set goes to VS (target code 2) with cause equal to its bit number minus one (1, 5 or 9). This happens only while virtualized, and only in VU mode or in VS mode with the VS-level enable set. Otherwise it is not taken.
- R8: When several target modes have an eligible interrupt, M wins over HS and HS wins over VS.
- R9: Within one target, bits are chosen in the order 11, 3, 7, 9, 1, 5, 10, 2, 6. That is external, then software, then timer, with M-level sources ahead of S-level sources and S-level sources ahead of guest sources.
- R10: The take strobe, target and cause reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pend | input | W | Pending interrupt vector |
| irq_en | input | W | Interrupt enable vector |
| m_deleg | input | W | Machine delegation mask (guest bits forced set internally) |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| virt_on | input | 1 | Hart runs virtualized |
| gie_m | input | 1 | M-level global enable |
| gie_hs | input | 1 | HS-level global enable |
| gie_vs | input | 1 | VS-level global enable |
| gdel_we | input | 1 | Write strobe for the guest delegation register |
| gdel_wdata | input | W | Write data for the guest delegation register |
| gdel_rdata | output | W | Current guest delegation register contents |
| take_irq | output | 1 | Take an interrupt now (registered) |
| take_tgt | output | 2 | Target mode: 0 M, 1 HS, 2 VS |
| take_cause | output | CW | Cause number reported to the target |

## Verification
The assertions assume the virtualization flag is raised only with privilege U or S, because a virtualized machine mode does not exist. They also assume the privilege code 2 never appears. The bench respects both assumptions: it changes privilege and the virtualization flag together in each scenario task and uses only codes 0, 1 and 3. Inputs change one time unit after a rising edge and are held until the sampled result, so every assertion sees stable, legal combinations.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

   typedef enum logic [1:0] {
      TGT_M  = 2'd0,
      TGT_HS = 2'd1,
      TGT_VS = 2'd2
   } tgt_e;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_S = 2'd1;
   localparam logic [1:0] PRV_M = 2'd3;

   localparam int unsigned NSRC = 9;
   // Highest priority first: M ext/sw/tmr, S ext/sw/tmr, guest ext/sw/tmr
   localparam int unsigned PRIO_ORDER [NSRC] = '{11, 3, 7, 9, 1, 5, 10, 2, 6};

   localparam int unsigned GBIT_SW  = 2;
   localparam int unsigned GBIT_TMR = 6;
   localparam int unsigned GBIT_EXT = 10;

   function automatic logic [63:0] guest_mask64();
      logic [63:0] m;
      m = '0;
      m[GBIT_SW]  = 1'b1;
      m[GBIT_TMR] = 1'b1;
      m[GBIT_EXT] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/hirq_gdeleg.sv
module hirq_gdeleg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   import hirq_pkg::*;

   localparam logic [W-1:0] WMASK = W'(guest_mask64());

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (we)
         q <= wdata & WMASK;
   end

   // R2: stored value equals masked write data
   a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(we)) |-> (q == ($past(wdata) & WMASK)));

   // R2: bits outside the guest set never become set
   a_r2_fixed_zero: assert property (@(posedge clk) disable iff (rst)
      ((q & ~WMASK) == '0));

endmodule

// File: rtl/hirq_pick.sv
module hirq_pick #(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          hit,
   output logic [CW-1:0] idx
);
   import hirq_pkg::*;

   always_comb begin
      hit = 1'b0;
      idx = '0;
      // walk lowest priority first so the highest one wins last
      for (int i = int'(NSRC) - 1; i >= 0; i--) begin
         if (vec[PRIO_ORDER[i]]) begin
            hit = 1'b1;
            idx = CW'(PRIO_ORDER[i]);
         end
      end
   end

endmodule

// File: rtl/hirq_resolve.sv
module hirq_resolve #(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  pend,
   input  logic [W-1:0]  en,
   input  logic [W-1:0]  mdel,
   input  logic [W-1:0]  gdel,
   input  logic [1:0]    priv,
   input  logic          virt,
   input  logic          ie_m,
   input  logic          ie_hs,
   input  logic          ie_vs,
   output logic          take_q,
   output logic [1:0]    tgt_q,
   output logic [CW-1:0] cause_q
);
   import hirq_pkg::*;

   localparam int unsigned NLVL  = 3;
   localparam logic [W-1:0] GMASK = W'(guest_mask64());

   logic [W-1:0]  act;
   logic [W-1:0]  mdel_eff;
   logic [W-1:0]  cand [NLVL];
   logic          glob [NLVL];
   logic          hit  [NLVL];
   logic [CW-1:0] idx  [NLVL];

   assign act      = pend & en;
   assign mdel_eff = mdel | GMASK;

   // candidate sets per target; guest bits stay in the HS set
   assign cand[0] = act & ~mdel_eff;
   assign cand[1] = act &  mdel_eff & ~gdel;
   assign cand[2] = act &  mdel_eff &  gdel & GMASK;

   assign glob[0] = (priv != PRV_M) || ie_m;
   assign glob[1] = virt || (priv == PRV_U) || ((priv == PRV_S) && ie_hs);
   assign glob[2] = virt && ((priv == PRV_U) || ((priv == PRV_S) && ie_vs));

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      hirq_pick #(.W(W), .CW(CW)) u_pick (
         .vec (cand[l]),
         .hit (hit[l]),
         .idx (idx[l])
      );
   end

   logic          fire_m, fire_hs, fire_vs;
   logic          take_d;
   logic [1:0]    tgt_d;
   logic [CW-1:0] cause_d;

   assign fire_m  = hit[0] && glob[0];
   assign fire_hs = hit[1] && glob[1];
   assign fire_vs = hit[2] && glob[2];

   always_comb begin
      take_d  = 1'b0;
      tgt_d   = TGT_M;
      cause_d = '0;
      if (fire_m) begin
         take_d  = 1'b1;
         tgt_d   = TGT_M;
         cause_d = idx[0];
      end else if (fire_hs) begin
         take_d  = 1'b1;
         tgt_d   = TGT_HS;
         cause_d = idx[1];
      end else if (fire_vs) begin
         take_d  = 1'b1;
         tgt_d   = TGT_VS;
         cause_d = idx[2] - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         take_q  <= 1'b0;
         tgt_q   <= TGT_M;
         cause_q <= '0;
      end else begin
         take_q  <= take_d;
         tgt_q   <= tgt_d;
         cause_q <= cause_d;
      end
   end

   // R3: an M take never carries a guest bit number
   a_r3_guest_not_m: assert property (@(posedge clk) disable iff (rst)
      (take_q && tgt_q == TGT_M) |->
         (cause_q != CW'(GBIT_SW) && cause_q != CW'(GBIT_TMR) && cause_q != CW'(GBIT_EXT)));

   // R5: virtualized HS candidate wins over a clear HS enable unless M fires
   a_r5_hs_when_virt: assert property (@(posedge clk) disable iff (rst)
      (virt && hit[1] && !fire_m) |=> (take_q && tgt_q == TGT_HS));

   // R7: VS causes are the guest bit numbers minus one and need virtualization
   a_r7_vs_cause: assert property (@(posedge clk) disable iff (rst)
      (take_q && tgt_q == TGT_VS) |->
         ($past(virt) && (cause_q == CW'(1) || cause_q == CW'(5) || cause_q == CW'(9))));

   // R8: an eligible M interrupt always decides the next take
   a_r8_m_first: assert property (@(posedge clk) disable iff (rst)
      fire_m |=> (take_q && tgt_q == TGT_M));

   // R6: no HS take out of machine mode when not virtualized
   a_r6_hs_not_in_m: assert property (@(posedge clk) disable iff (rst)
      (!virt && priv == PRV_M && !fire_m) |=> !take_q);

endmodule

// File: rtl/hyp_irq_router.sv
module hyp_irq_router #(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  irq_pend,
   input  logic [W-1:0]  irq_en,
   input  logic [W-1:0]  m_deleg,
   input  logic [1:0]    cur_priv,
   input  logic          virt_on,
   input  logic          gie_m,
   input  logic          gie_hs,
   input  logic          gie_vs,
   input  logic          gdel_we,
   input  logic [W-1:0]  gdel_wdata,
   output logic [W-1:0]  gdel_rdata,
   output logic          take_irq,
   output logic [1:0]    take_tgt,
   output logic [CW-1:0] take_cause
);

   initial begin
      assert (W >= 12 && W <= 64) else $fatal(1, "vector width out of range");
      assert (CW >= $clog2(W)) else $fatal(1, "cause width too small");
   end

   hirq_gdeleg #(.W(W)) u_gdel (
      .clk   (clk),
      .rst   (rst),
      .we    (gdel_we),
      .wdata (gdel_wdata),
      .q     (gdel_rdata)
   );

   hirq_resolve #(.W(W), .CW(CW)) u_res (
      .clk     (clk),
      .rst     (rst),
      .pend    (irq_pend),
      .en      (irq_en),
      .mdel    (m_deleg),
      .gdel    (gdel_rdata),
      .priv    (cur_priv),
      .virt    (virt_on),
      .ie_m    (gie_m),
      .ie_hs   (gie_hs),
      .ie_vs   (gie_vs),
      .take_q  (take_irq),
      .tgt_q   (take_tgt),
      .cause_q (take_cause)
   );

   // R1: outputs are cleared in the cycle after reset
   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!take_irq && gdel_rdata == '0));

endmodule

// File: tb/hyp_irq_router_tb.sv
module hyp_irq_router_tb;
   localparam int W  = 16;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  irq_pend = '0, irq_en = '0, m_deleg = '0, gdel_wdata = '0;
   logic [1:0]    cur_priv = 2'd0;
   logic          virt_on = 1'b0, gie_m = 1'b0, gie_hs = 1'b0, gie_vs = 1'b0;
   logic          gdel_we = 1'b0;
   logic [W-1:0]  gdel_rdata;
   logic          take_irq;
   logic [1:0]    take_tgt;
   logic [CW-1:0] take_cause;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   hyp_irq_router #(.W(W), .CW(CW)) u_dut (
      .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en),
      .m_deleg(m_deleg), .cur_priv(cur_priv), .virt_on(virt_on),
      .gie_m(gie_m), .gie_hs(gie_hs), .gie_vs(gie_vs),
      .gdel_we(gdel_we), .gdel_wdata(gdel_wdata), .gdel_rdata(gdel_rdata),
      .take_irq(take_irq), .take_tgt(take_tgt), .take_cause(take_cause)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // expected: take, target, cause (cause checked only when taken)
   task automatic expect_take(input string req, input bit tk, input int tg, input int cs);
      chk(req, int'(take_irq), int'(tk));
      if (tk) begin
         chk(req, int'(take_tgt), tg);
         chk(req, int'(take_cause), cs);
      end
   endtask

   task automatic set_gdel(input logic [W-1:0] v);
      gdel_we = 1'b1; gdel_wdata = v;
      step();
      gdel_we = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] p, input logic v);
      cur_priv = p; virt_on = v;
   endtask

   task automatic t_reset();
      chk("R1 take", int'(take_irq), 0);
      chk("R1 gdel", int'(gdel_rdata), 0);
   endtask

   task automatic t_gdel_mask();
      set_gdel(16'hFFFF);
      chk("R2 mask", int'(gdel_rdata), 16'h0444);
      set_gdel(16'hFBBB);
      chk("R2 zero", int'(gdel_rdata), 0);
   endtask

   task automatic t_guest_not_m();
      set_gdel('0);
      m_deleg = '0; irq_en = '1; irq_pend = 16'h0004;
      set_mode(2'd0, 1'b0); gie_m = 1'b1;
      step();
      expect_take("R3 guest to HS", 1'b1, 1, 2);
      irq_pend = 16'h0400;
      step();
      expect_take("R3 ext guest", 1'b1, 1, 10);
   endtask

   task automatic t_m_target();
      m_deleg = '0; irq_pend = 16'h0080; set_mode(2'd1, 1'b0); gie_m = 1'b0;
      step();
      expect_take("R4 below M", 1'b1, 0, 7);
      set_mode(2'd3, 1'b0);
      step();
      expect_take("R4 M mie off", 1'b0, 0, 0);
      gie_m = 1'b1;
      step();
      expect_take("R4 M mie on", 1'b1, 0, 7);
   endtask

   task automatic t_hs_virt();
      m_deleg = '1; gie_hs = 1'b0; set_mode(2'd1, 1'b1);
      irq_pend = 16'h0040;
      step();
      expect_take("R5 guest tmr", 1'b1, 1, 6);
      irq_pend = 16'h0020;
      step();
      expect_take("R5 S tmr", 1'b1, 1, 5);
      set_mode(2'd0, 1'b1); irq_pend = 16'h0004;
      step();
      expect_take("R5 VU guest sw", 1'b1, 1, 2);
   endtask

   task automatic t_hs_native();
      m_deleg = '1; irq_pend = 16'h0002; set_mode(2'd1, 1'b0); gie_hs = 1'b0;
      step();
      expect_take("R6 S sie off", 1'b0, 0, 0);
      gie_hs = 1'b1;
      step();
      expect_take("R6 S sie on", 1'b1, 1, 1);
      set_mode(2'd3, 1'b0);
      step();
      expect_take("R6 in M", 1'b0, 0, 0);
      gie_hs = 1'b0; set_mode(2'd0, 1'b0);
      step();
      expect_take("R6 in U", 1'b1, 1, 1);
   endtask

   task automatic t_vs();
      set_gdel(16'h0444);
      m_deleg = '1; gie_hs = 1'b0; set_mode(2'd1, 1'b1); gie_vs = 1'b1;
      irq_pend = 16'h0400;
      step();
      expect_take("R7 VS ext", 1'b1, 2, 9);
      gie_vs = 1'b0;
      step();
      expect_take("R7 vsie off", 1'b0, 0, 0);
      set_mode(2'd0, 1'b1); irq_pend = 16'h0004;
      step();
      expect_take("R7 VU sw", 1'b1, 2, 1);
      irq_pend = 16'h0040;
      step();
      expect_take("R7 VU tmr", 1'b1, 2, 5);
      set_mode(2'd0, 1'b0);
      step();
      expect_take("R7 not virt", 1'b0, 0, 0);
   endtask

   task automatic t_order();
      // gdel = 0x444 from t_vs
      m_deleg = 16'hFF7F; set_mode(2'd0, 1'b1); gie_vs = 1'b1;
      irq_pend = 16'h0482;
      step();
      expect_take("R8 M first", 1'b1, 0, 7);
      irq_pend = 16'h0402;
      step();
      expect_take("R8 HS over VS", 1'b1, 1, 1);
      m_deleg = '0; irq_pend = 16'h0888;
      step();
      expect_take("R9 M ext", 1'b1, 0, 11);
      irq_pend = 16'h0088;
      step();
      expect_take("R9 M sw", 1'b1, 0, 3);
      irq_pend = 16'h0280;
      step();
      expect_take("R9 M src first", 1'b1, 0, 7);
      m_deleg = '1; set_gdel('0); irq_pend = 16'h0420;
      step();
      expect_take("R9 S before guest", 1'b1, 1, 5);
      irq_pend = 16'h0044;
      step();
      expect_take("R9 guest sw", 1'b1, 1, 2);
   endtask

   task automatic t_latency();
      irq_pend = '0;
      step();
      irq_pend = 16'h0002; m_deleg = '1; set_mode(2'd0, 1'b0);
      #1;
      chk("R10 before edge", int'(take_irq), 0);
      step();
      chk("R10 after edge", int'(take_irq), 1);
      irq_pend = '0;
      #1;
      chk("R10 hold", int'(take_irq), 1);
      step();
      chk("R10 clear", int'(take_irq), 0);
   endtask

   initial begin
      repeat (3) step();
      rst = 1'b0;
      step();
      t_reset();
      t_gdel_mask();
      t_guest_not_m();
      t_m_target();
      t_hs_virt();
      t_hs_native();
      t_vs();
      t_order();
      t_latency();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule